// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Access

This block is a 32-bit down-counting watchdog that sits on an APB slave port. A single-cycle count-enable input (`tick_en`) advances the counter. The count source is kept separate from the bus clock, so the counter can run at any rate that is a division of that clock. When the count runs out the first time, the block latches a raw interrupt flag. If the count runs out again before software has cleared that flag, the block latches a reset flag and freezes the counter. The block then drives a reset request to an external reset controller.

Software controls the block through registers. It sets the reload value, enables the interrupt and reset outputs, and clears the interrupt, which also restarts the countdown. A magic-key lock protects the configuration against stray writes. A test mode lets a register drive both outputs directly. A read-only identification area identifies the block to software.

A build parameter selects a reduced variant. In that variant the interrupt enable cannot be cleared again once it is set, and the test registers are absent.

Top module: `twostage_wdog`

## Requirements
- R1: After synchronous reset the control, raw status, lock, test-control and test-output registers read 0. The reload register (offset 0x000) reads 0xFFFFFFFF and the counter runs, starting from 0xFFFFFFFF.
- R2: Each `tick_en` pulse on a running counter lowers the count (offset 0x004) by one. A tick that finds the count at 0 reloads it from the reload value.
- R3: Writing offset 0x000 sets both the reload value and the count to the written data and restarts a halted counter.
- R4: A tick that takes the count from 1 to 0 is an expiry. If raw status (offset 0x010, bit 0) is clear, an expiry sets it. If raw status is already set, the expiry sets the internal reset flag and halts the counter. The reset flag clears only on reset.
- R5: Control (offset 0x008) bit 0 enables the interrupt and bit 1 enables the reset. `wd_irq` is raw status AND bit 0, and `wd_rst_req` is the reset flag AND bit 1. Offset 0x014 reads raw status AND bit 0.
- R6: A write of any data to offset 0x00C clears raw status and reloads the count from the reload value, without restarting a halted counter.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block and any other value locks it. Offset 0xC00 reads 1 when locked. While locked, every write to any other offset is dropped.
- R8: When test control (offset 0xF00) bit 0 is 1, `wd_rst_req` follows test-output (offset 0xF04) bit 0 and `wd_irq` follows bit 1.
- R9: Control keeps only bits 1:0 of written data. Writes to read-only offsets (0x004, 0x010, 0x014, the ID area) change nothing. Reads of 0x00C, 0xF04 and unmapped offsets return 0.
- R10: Offsets 0xFD0 to 0xFFC read one byte each. The standard build returns 0x04 at 0xFD0, 0x51 at 0xFE0, 0xA7 at 0xFE4, 0x1B at 0xFE8, and 0x0D, 0xF0, 0x05, 0xB1 at 0xFF0 to 0xFFC; all other ID offsets return 0. The variant returns 0x00 at 0xFD0 and 0x52 at 0xFE0.
- R11: With `STICKY_CTRL=1`, control writes are dropped once control bit 0 is set. Offsets 0xF00 and 0xF04 then act as unmapped: they read 0 and writes to them have no effect on the outputs.
- R12: `pready` is always 1 and `pslverr` is always 0. A write takes effect in the cycle where `psel`, `penable` and `pwrite` are all high.
- R13: With a reload value of 0, every tick is an expiry. A load or interrupt-clear write in the same cycle as a tick takes precedence: that tick neither counts nor expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle count enable |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| wd_irq | output | 1 | Interrupt request |
| wd_rst_req | output | 1 | Reset request to an external reset controller |

## Verification
Read data is a combinational function of the address and the registered state. The bench therefore samples `prdata` one nanosecond into the access cycle, before the rising edge. Writes and ticks change state on the next rising edge, and `wd_irq` and `wd_rst_req` reflect that state straight away. Both outputs are therefore compared at the falling edge that follows each applied cycle. A read issued in the cycle after a write or tick sees its effect: for example, the count after a load, raw status after the expiring tick, or the reset request after the second expiry.

// File: rtl/twostage_wdog_pkg.sv
// Package: register offsets, unlock key and identification bytes shared by
// the watchdog modules. Assumes a 12-bit byte address space.
package twostage_wdog_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_ICLR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'h C00;
    localparam logic [ADDR_W-1:0] OFS_ITCTL = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_ITOUT = 12'hF04;
    localparam logic [ADDR_W-1:0] OFS_ID_LO = 12'hFD0;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    // Identification byte for word index 0 (0xFD0) .. 11 (0xFFC).
    function automatic logic [7:0] id_byte(input logic variant, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = variant ? 8'h00 : 8'h04;
            4'd4:    b = variant ? 8'h52 : 8'h51;
            4'd5:    b = 8'hA7;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/twostage_wdog_cnt.sv
// Down counter with reload. Assumes tick is a one-cycle enable and that
// load/clear writes in the same cycle win over a tick. Flags an expiry on
// the 1->0 step, or on every tick while the reload value is zero.
module twostage_wdog_cnt #(
    parameter int                 DATA_W     = 32,
    parameter logic [DATA_W-1:0]  RESET_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_wr,
    input  logic              clear_wr,
    input  logic              halt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic              expire_o
);
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic              run_q;
    logic              at_one;
    logic              at_zero;

    assign at_one   = (count_q == DATA_W'(1));
    assign at_zero  = (count_q == '0);
    assign expire_o = tick & run_q & ~load_wr & ~clear_wr
                    & (at_one | (at_zero & (reload_q == '0)));
    assign reload_o = reload_q;
    assign count_o  = count_q;

    // Reload value, count and run flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RESET_LOAD;
            count_q  <= RESET_LOAD;
            run_q    <= 1'b1;
        end else if (load_wr) begin
            reload_q <= wdata;
            count_q  <= wdata;
            run_q    <= 1'b1;
        end else if (clear_wr) begin
            count_q  <= reload_q;
        end else if (tick && run_q) begin
            count_q  <= at_zero ? reload_q : count_q - DATA_W'(1);
            if (halt) run_q <= 1'b0;
        end
    end

    // R2: a plain tick lowers the count by one
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run_q && !load_wr && !clear_wr && count_q > DATA_W'(1))
        |=> (count_q == $past(count_q) - DATA_W'(1)));

    // R4: a halted counter holds its value
    p_halted_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_wr && !clear_wr) |=> $stable(count_q));
endmodule

// File: rtl/twostage_wdog_stat.sv
// Expiry status and output selection. Assumes expire is already suppressed
// when an interrupt-clear write occurs. The first expiry raises raw status;
// an expiry with raw status set latches the reset flag and halts the count.
module twostage_wdog_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clear_wr,
    input  logic int_en,
    input  logic rst_en,
    input  logic test_mode,
    input  logic test_irq,
    input  logic test_rst,
    output logic halt_o,
    output logic raw_o,
    output logic irq_o,
    output logic rst_req_o
);
    logic raw_q;
    logic fired_q;

    assign halt_o = expire & raw_q;
    assign raw_o  = raw_q;

    // Raw interrupt and sticky reset flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            if (clear_wr)    raw_q   <= 1'b0;
            else if (expire) raw_q   <= 1'b1;
            if (halt_o)      fired_q <= 1'b1;
        end
    end

    // Output selection between normal logic and test override.
    always_comb begin
        if (test_mode) begin
            irq_o     = test_irq;
            rst_req_o = test_rst;
        end else begin
            irq_o     = raw_q & int_en;
            rst_req_o = fired_q & rst_en;
        end
    end

    // R4: second expiry latches the reset flag
    p_second_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && raw_q) |=> fired_q);

    // R4: reset flag never drops outside reset
    p_fired_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fired_q |=> fired_q);

    // R6: clear write drops raw status
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> !raw_q);
endmodule

// File: rtl/twostage_wdog.sv
// APB watchdog top: address decode, control/lock/test registers and read
// mux. Assumes zero-wait APB; writes act when psel, penable and pwrite are
// high. STICKY_CTRL selects the variant with sticky interrupt enable and no
// test registers.
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              wd_irq,
    output logic              wd_rst_req
);
    localparam logic [DATA_W-1:0] LOAD_INIT = '1;

    logic              wr_en;
    logic              wr_ok;
    logic              load_wr;
    logic              clear_wr;
    logic [1:0]        ctrl_q;
    logic              locked_q;
    logic              itcr_q;
    logic [1:0]        itop_q;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] count;
    logic              expire;
    logic              halt;
    logic              raw;

    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
    assign wr_en    = psel & penable & pwrite;
    assign wr_ok    = wr_en & (~locked_q | (paddr == OFS_LOCK));
    assign load_wr  = wr_ok & (paddr == OFS_LOAD);
    assign clear_wr = wr_ok & (paddr == OFS_ICLR);

    // Control register, sticky in the variant once interrupts are enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 2'b00;
        else if (wr_ok && paddr == OFS_CTRL && !(STICKY_CTRL && ctrl_q[0]))
            ctrl_q <= pwdata[1:0];
    end

    // Write lock: key unlocks, anything else locks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (wr_en && paddr == OFS_LOCK)
            locked_q <= (pwdata != UNLOCK_KEY);
    end

    generate
        if (!STICKY_CTRL) begin : g_test_regs
            // Test control and test output registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    itcr_q <= 1'b0;
                    itop_q <= 2'b00;
                end else if (wr_ok && paddr == OFS_ITCTL) begin
                    itcr_q <= pwdata[0];
                end else if (wr_ok && paddr == OFS_ITOUT) begin
                    itop_q <= pwdata[1:0];
                end
            end
        end else begin : g_no_test_regs
            assign itcr_q = 1'b0;
            assign itop_q = 2'b00;
        end
    endgenerate

    twostage_wdog_cnt #(.DATA_W(DATA_W), .RESET_LOAD(LOAD_INIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .load_wr  (load_wr),
        .clear_wr (clear_wr),
        .halt     (halt),
        .wdata    (pwdata),
        .reload_o (reload),
        .count_o  (count),
        .expire_o (expire)
    );

    twostage_wdog_stat u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .clear_wr  (clear_wr),
        .int_en    (ctrl_q[0]),
        .rst_en    (ctrl_q[1]),
        .test_mode (itcr_q),
        .test_irq  (itop_q[1]),
        .test_rst  (itop_q[0]),
        .halt_o    (halt),
        .raw_o     (raw),
        .irq_o     (wd_irq),
        .rst_req_o (wd_rst_req)
    );

    // Read data multiplexer; write-only and unmapped offsets give zero.
    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_LOAD:  prdata = reload;
            OFS_COUNT: prdata = count;
            OFS_CTRL:  prdata = DATA_W'(ctrl_q);
            OFS_RAW:   prdata = DATA_W'(raw);
            OFS_MSK:   prdata = DATA_W'(raw & ctrl_q[0]);
            OFS_LOCK:  prdata = DATA_W'(locked_q);
            OFS_ITCTL: prdata = DATA_W'(itcr_q);
            default: begin
                if (paddr >= OFS_ID_LO && paddr[1:0] == 2'b00)
                    prdata = DATA_W'(id_byte(STICKY_CTRL, paddr[5:2] - 4'd4));
            end
        endcase
    end

    // R7: locked block drops writes to other offsets
    p_lock_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_en && paddr != OFS_LOCK)
        |=> ($stable(ctrl_q) && $stable(itcr_q) && $stable(itop_q)));

    // R11: variant keeps interrupt enable once set
    p_sticky_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (STICKY_CTRL && ctrl_q[0]) |=> ctrl_q[0]);
endmodule

// File: tb/sim_twostage_wdog.sv
module sim_twostage_wdog;
    localparam logic [31:0] KEY = 32'h1ACC_E551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, wd_irq, wd_rst_req;

    logic        v_tick = 1'b0, v_psel = 1'b0, v_pen = 1'b0, v_pwr = 1'b0;
    logic [11:0] v_addr = '0;
    logic [31:0] v_wdata = '0;
    logic [31:0] v_rdata;
    logic        v_ready, v_err, v_irq, v_rst;

    int checks = 0;
    int failures = 0;

    // model state
    logic [31:0] m_rel, m_cnt;
    logic        m_run, m_ris, m_rst, m_lock, m_itcr;
    logic [1:0]  m_ctrl, m_itop;

    always #2 clk = ~clk;

    twostage_wdog u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req));

    twostage_wdog #(.STICKY_CTRL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(v_tick), .psel(v_psel), .penable(v_pen),
        .pwrite(v_pwr), .paddr(v_addr), .pwdata(v_wdata), .prdata(v_rdata),
        .pready(v_ready), .pslverr(v_err), .wd_irq(v_irq), .wd_rst_req(v_rst));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_rel;
            12'h004: return m_cnt;
            12'h008: return {30'd0, m_ctrl};
            12'h010: return {31'd0, m_ris};
            12'h014: return {31'd0, m_ris & m_ctrl[0]};
            12'hC00: return {31'd0, m_lock};
            12'hF00: return {31'd0, m_itcr};
            12'hFD0: return 32'h04;
            12'hFE0: return 32'h51;
            12'hFE4: return 32'hA7;
            12'hFE8: return 32'h1B;
            12'hFF0: return 32'h0D;
            12'hFF4: return 32'hF0;
            12'hFF8: return 32'h05;
            12'hFFC: return 32'hB1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h000: return "R3";
            12'h004: return "R2";
            12'h010: return "R4";
            12'h014: return "R5";
            12'hC00: return "R7";
            12'hF00: return "R8";
            default: return (a >= 12'hFD0) ? "R10" : "R9";
        endcase
    endfunction

    task automatic m_reset();
        m_rel = '1; m_cnt = '1; m_run = 1'b1; m_ris = 1'b0; m_rst = 1'b0;
        m_lock = 1'b0; m_itcr = 1'b0; m_ctrl = 2'b00; m_itop = 2'b00;
    endtask

    task automatic m_step(input logic tk, input logic wr, input logic [11:0] a, input logic [31:0] d);
        logic wen, ld, clr, ex;
        wen = wr && (!m_lock || a == 12'hC00);
        ld  = wen && a == 12'h000;
        clr = wen && a == 12'h00C;
        ex  = tk && m_run && !ld && !clr && (m_cnt == 1 || (m_cnt == 0 && m_rel == 0));
        if (ex && m_ris) begin m_rst = 1'b1; m_run = 1'b0; end
        if (clr) m_ris = 1'b0; else if (ex) m_ris = 1'b1;
        if (ld) begin m_rel = d; m_cnt = d; m_run = 1'b1; end
        else if (clr) m_cnt = m_rel;
        else if (tk && (m_run || ex)) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
        if (wen && a == 12'h008) m_ctrl = d[1:0];
        if (wr && a == 12'hC00) m_lock = (d != KEY);
        if (wen && a == 12'hF00) m_itcr = d[0];
        if (wen && a == 12'hF04) m_itop = d[1:0];
    endtask

    // One bus cycle on u0; starts just after a falling edge.
    task automatic cyc(input logic tk, input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] d);
        logic ei, er;
        tick_en = tk; psel = wr | rd; penable = wr | rd; pwrite = wr; paddr = a; pwdata = d;
        #1;
        if (rd) chk(tag_of(a), prdata, m_read(a));
        @(posedge clk);
        m_step(tk, wr, a, d);
        @(negedge clk);
        tick_en = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        ei = m_itcr ? m_itop[1] : (m_ris & m_ctrl[0]);
        er = m_itcr ? m_itop[0] : (m_rst & m_ctrl[1]);
        chk(m_itcr ? "R8 irq" : "R5 irq", {31'd0, wd_irq}, {31'd0, ei});
        chk(m_itcr ? "R8 rst" : "R5 rst", {31'd0, wd_rst_req}, {31'd0, er});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1'b0, 1'b1, 1'b0, a, d); endtask
    task automatic tk(input int n); for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 12'h0, 32'h0); endtask

    task automatic rd_lit(input string tag, input logic [11:0] a, input logic [31:0] exp);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        chk(tag, prdata, exp);
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic v_wr(input logic [11:0] a, input logic [31:0] d);
        v_psel = 1'b1; v_pen = 1'b1; v_pwr = 1'b1; v_addr = a; v_wdata = d;
        @(posedge clk); @(negedge clk);
        v_psel = 1'b0; v_pen = 1'b0; v_pwr = 1'b0;
    endtask

    task automatic v_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        v_psel = 1'b1; v_pen = 1'b1; v_pwr = 1'b0; v_addr = a;
        #1;
        chk(tag, v_rdata, exp);
        @(posedge clk); @(negedge clk);
        v_psel = 1'b0; v_pen = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] pool [16];
        pool = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'hC00, 12'hF00,
                 12'hF04, 12'hFD0, 12'hFE0, 12'hFFC, 12'h020, 12'h3FC, 12'h008, 12'h000};
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R12 handshake
        rd_lit("R1 load", 12'h000, 32'hFFFF_FFFF);
        rd_lit("R1 ctrl", 12'h008, 32'h0);
        rd_lit("R1 raw", 12'h010, 32'h0);
        rd_lit("R1 lock", 12'hC00, 32'h0);
        rd_lit("R1 itctl", 12'hF00, 32'h0);
        chk("R12 ready", {31'd0, pready}, 32'd1);
        chk("R12 err", {31'd0, pslverr}, 32'd0);
        tk(2);
        rd_lit("R1 R2 count", 12'h004, 32'hFFFF_FFFD);

        // R3, R4, R5 two-stage expiry
        wr(12'h000, 32'd3);
        rd_lit("R3 count", 12'h004, 32'd3);
        wr(12'h008, 32'd3);
        tk(3);
        rd_lit("R4 raw", 12'h010, 32'd1);
        rd_lit("R5 masked", 12'h014, 32'd1);
        chk("R5 irq high", {31'd0, wd_irq}, 32'd1);
        tk(4);
        chk("R4 rst req", {31'd0, wd_rst_req}, 32'd1);
        tk(2);
        rd_lit("R4 halted", 12'h004, 32'd0);

        // R6 clear
        wr(12'h00C, 32'h0);
        rd_lit("R6 raw", 12'h010, 32'd0);
        rd_lit("R6 count", 12'h004, 32'd3);
        chk("R6 irq low", {31'd0, wd_irq}, 32'd0);

        // R7 lock
        wr(12'hC00, 32'h0);
        rd_lit("R7 locked", 12'hC00, 32'd1);
        wr(12'h008, 32'h0);
        rd_lit("R7 ctrl kept", 12'h008, 32'd3);
        wr(12'hC00, KEY);
        rd_lit("R7 unlocked", 12'hC00, 32'd0);

        // R9 masking, read-only, unmapped
        wr(12'h008, 32'hFFFF_FFFC);
        rd_lit("R9 ctrl mask", 12'h008, 32'd0);
        wr(12'h004, 32'd5);
        rd_lit("R9 count ro", 12'h004, 32'd3);
        rd_lit("R9 iclr rd", 12'h00C, 32'd0);
        rd_lit("R9 unmapped", 12'h100, 32'd0);

        // R8 test override
        wr(12'hF04, 32'd2);
        wr(12'hF00, 32'd1);
        chk("R8 irq", {31'd0, wd_irq}, 32'd1);
        chk("R8 rst", {31'd0, wd_rst_req}, 32'd0);
        wr(12'hF04, 32'd1);
        chk("R8 rst drive", {31'd0, wd_rst_req}, 32'd1);
        rd_lit("R9 itout rd", 12'hF04, 32'd0);
        wr(12'hF00, 32'd0);

        // R10 identification
        rd_lit("R10 id0", 12'hFD0, 32'h04);
        rd_lit("R10 id4", 12'hFE0, 32'h51);
        rd_lit("R10 id8", 12'hFF0, 32'h0D);
        rd_lit("R10 id11", 12'hFFC, 32'hB1);

        // R13 zero reload and write precedence
        wr(12'h000, 32'd0);
        tk(1);
        rd_lit("R13 zero expiry", 12'h010, 32'd1);
        cyc(1'b1, 1'b1, 1'b0, 12'h000, 32'd5);
        rd_lit("R13 precedence", 12'h004, 32'd5);

        // random phase against model
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic w;
            a = pool[$urandom % 16];
            w = ($urandom % 3) == 0;
            d = $urandom;
            if (a == 12'h000) d = d & 32'h7;
            if (a == 12'hC00) d = (($urandom % 2) == 0) ? KEY : d;
            if (a == 12'hF00) d = {31'd0, ($urandom % 4) == 0};
            if (a == 12'h00C && ($urandom % 4) != 0) w = 1'b0;
            cyc(($urandom % 2) == 0, w, !w, a, d);
        end

        // R11 variant
        v_wr(12'h008, 32'd1);
        v_wr(12'h008, 32'd2);
        v_rd("R11 sticky", 12'h008, 32'd1);
        v_wr(12'hF04, 32'd3);
        v_wr(12'hF00, 32'd1);
        v_rd("R11 itctl", 12'hF00, 32'd0);
        chk("R11 irq", {31'd0, v_irq}, 32'd0);
        chk("R11 rst", {31'd0, v_rst}, 32'd0);
        v_rd("R10 var id0", 12'hFD0, 32'h00);
        v_rd("R10 var id4", 12'hFE0, 32'h52);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule